// File: doc/BRIEF.md
# Nested Interrupt Priority Status Tracker

This block keeps track of which interrupt priority levels are currently in service when nested handling is turned on. There are eight levels, and level 0 is the most urgent. Software fetches an interrupt vector, and the vector-read strobe arrives with the priority of the request that won arbitration. If nesting is enabled at that moment, the block marks that level as active in its status register.

From the active set, the block builds a blocking mask. Every level at or below the urgency of the most urgent active level is blocked. The interrupt controller uses this mask to hold back pending requests.

Software retires levels through the write strobe of the register port. Each write clears only the most urgent active level, so nested handlers unwind strictly in order. Write data has no meaning, so the port carries a write strobe and no data. The status reads back zero-extended to a 32-bit word.

Top module: `nest_prio_tracker`

## Requirements
- R1: After a synchronous reset, `rdata` reads 0x00000000 and `blk_mask` reads 0x00. Reset takes precedence over any strobe in the same cycle.
- R2: A vector-read strobe with `nest_en` high sets status bit `vec_prio`. The other bits stay as they were (apart from R7).
- R3: A vector-read strobe with `nest_en` low leaves the status unchanged.
- R4: `blk_mask[i]` is 1 exactly when some status bit j with j <= i is set. This makes the mask a thermometer from the most urgent active level up to bit 7. It is 0x00 when no level is active.
- R5: Each write strobe clears only the lowest-numbered set status bit. For example, 0x09 becomes 0x08 and then 0x00, and 0xFF unwinds one bit per write from bit 0 upward.
- R6: A write strobe while the status is 0x00 leaves it at 0x00.
- R7: When a write strobe and an enabled vector-read strobe fall in the same cycle, the clear is applied to the old status first and the new level bit is set afterwards. For example, 0xA4 with priority 1 gives 0xA2, and 0x80 with priority 7 gives 0x80.
- R8: `rdata` bits 31 to 8 always read 0.
- R9: Both `rdata` and `blk_mask` take their new values at the same clock edge that samples the strobes. With no strobe, both hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe; retires the most urgent active level |
| rdata | output | 32 | Status register read value, zero-extended |
| vec_rd | input | 1 | Vector-read strobe |
| vec_prio | input | 3 | Priority of the request being served |
| nest_en | input | 1 | Nesting enable |
| blk_mask | output | 8 | Registered mask of blocked levels |

## Verification
The two operations that can collide are a retiring write and an enabled vector fetch. Both land in the same register at the same edge. The vector table puts both strobes in one cycle several times:
- the new level equals the level being retired;
- the new level is more urgent than the level being retired;
- the new level is the least urgent level.

Each result is judged against a value worked out by hand with the rule "clear the old lowest bit, then set the new one". The blocking mask is recomputed in the bench from that expected status.

// File: rtl/nest_prio_pkg.sv
package nest_prio_pkg;
  localparam int unsigned NPT_LEVELS = 8;
  localparam int unsigned NPT_REG_W  = 32;
endpackage

// File: rtl/npt_lowest_bit.sv
module npt_lowest_bit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] onehot
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_scan
    assign onehot[i]  = vec[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | vec[i];
  end
endmodule

// File: rtl/npt_therm_mask.sv
module npt_therm_mask #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] mask
);
  assign mask[0] = vec[0];
  for (genvar i = 1; i < W; i++) begin : g_fill
    assign mask[i] = mask[i-1] | vec[i];
  end
endmodule

// File: rtl/npt_level_decode.sv
module npt_level_decode #(
  parameter int unsigned W  = 8,
  parameter int unsigned PW = 3
) (
  input  logic          en,
  input  logic [PW-1:0] idx,
  output logic [W-1:0]  onehot
);
  for (genvar i = 0; i < W; i++) begin : g_dec
    assign onehot[i] = en && (idx == PW'(i));
  end
endmodule

// File: rtl/nest_prio_tracker.sv
module nest_prio_tracker
  import nest_prio_pkg::*;
#(
  parameter int unsigned LEVELS = NPT_LEVELS,
  parameter int unsigned REG_W  = NPT_REG_W,
  parameter int unsigned PRIO_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  output logic [REG_W-1:0]  rdata,
  input  logic              vec_rd,
  input  logic [PRIO_W-1:0] vec_prio,
  input  logic              nest_en,
  output logic [LEVELS-1:0] blk_mask
);
  localparam int unsigned PAD_W = REG_W - LEVELS;

  logic [LEVELS-1:0] status_q, status_d;
  logic [LEVELS-1:0] retire_bit, enter_bit, mask_d;
  logic              enter_en;

  assign enter_en = vec_rd & nest_en;

  // Most urgent active level: the candidate for retirement.
  npt_lowest_bit #(.W(LEVELS)) u_lowest (
    .vec    (status_q),
    .onehot (retire_bit)
  );

  npt_level_decode #(.W(LEVELS), .PW(PRIO_W)) u_decode (
    .en     (enter_en),
    .idx    (vec_prio),
    .onehot (enter_bit)
  );

  // Clear first, then set: a same-cycle entry survives the retire.
  always_comb begin
    status_d = status_q;
    if (wr_en) status_d = status_d & ~retire_bit;
    status_d = status_d | enter_bit;
  end

  npt_therm_mask #(.W(LEVELS)) u_mask (
    .vec  (status_d),
    .mask (mask_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      blk_mask <= '0;
    end else begin
      status_q <= status_d;
      blk_mask <= mask_d;
    end
  end

  assign rdata = {{PAD_W{1'b0}}, status_q};
endmodule

// File: rtl/nest_prio_tracker_chk.sv
module nest_prio_tracker_chk #(
  parameter int unsigned LEVELS = 8,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned PRIO_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [REG_W-1:0]  rdata,
  input logic              vec_rd,
  input logic [PRIO_W-1:0] vec_prio,
  input logic              nest_en,
  input logic [LEVELS-1:0] blk_mask
);
  logic [LEVELS-1:0] st;
  assign st = rdata[LEVELS-1:0];

  a_r2_enter_sets: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && nest_en) |=> ((rdata >> $past(vec_prio)) & REG_W'(1)) != '0);

  a_r3_no_nest_hold: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !nest_en && !wr_en) |=> $stable(rdata));

  a_r5_one_retired: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !vec_rd && st != '0) |=>
      ($countones(st) + 1 == $countones($past(st))) && ((st & ~$past(st)) == '0));

  a_r6_empty_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !vec_rd && st == '0) |=> st == '0);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !vec_rd) |=> ($stable(rdata) && $stable(blk_mask)));

  always @(negedge clk) begin
    if (!rst) begin
      a_r8_pad_zero: assert (rdata[REG_W-1:LEVELS] == '0);
      // R4: mask edge sits on the most urgent active level, and covers the status
      a_r4_mask_shape: assert ((blk_mask & ~(blk_mask << 1)) == (st & (~st + 1'b1)));
      a_r4_mask_cover: assert ((st & ~blk_mask) == '0);
    end
  end
endmodule

bind nest_prio_tracker nest_prio_tracker_chk #(
  .LEVELS(LEVELS), .REG_W(REG_W), .PRIO_W(PRIO_W)
) u_chk (.*);

// File: tb/nest_prio_tracker_bench.sv
module nest_prio_tracker_bench;
  localparam int CLK_P = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        vec_rd = 1'b0;
  logic [2:0]  vec_prio = '0;
  logic        nest_en = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  blk_mask;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  nest_prio_tracker u_nest_prio_tracker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rdata(rdata),
    .vec_rd(vec_rd), .vec_prio(vec_prio), .nest_en(nest_en), .blk_mask(blk_mask)
  );

  // {wr, vec, nest, prio[2:0], expected status[7:0]}
  localparam logic [13:0] VT [NV] = '{
    {1'b0,1'b1,1'b1,3'd3,8'h08},  // R2
    {1'b0,1'b1,1'b1,3'd0,8'h09},  // R2
    {1'b1,1'b0,1'b0,3'd0,8'h08},  // R5
    {1'b1,1'b0,1'b0,3'd0,8'h00},  // R5
    {1'b1,1'b0,1'b0,3'd0,8'h00},  // R6
    {1'b0,1'b1,1'b0,3'd5,8'h00},  // R3
    {1'b0,1'b1,1'b1,3'd5,8'h20},  // R2
    {1'b0,1'b1,1'b1,3'd7,8'hA0},  // R2
    {1'b0,1'b1,1'b1,3'd2,8'hA4},  // R2
    {1'b1,1'b1,1'b1,3'd1,8'hA2},  // R7
    {1'b1,1'b1,1'b1,3'd1,8'hA2},  // R7
    {1'b0,1'b0,1'b1,3'd4,8'hA2},  // R9
    {1'b1,1'b1,1'b0,3'd0,8'hA0},  // R3 with R5
    {1'b1,1'b0,1'b0,3'd0,8'h80},  // R5
    {1'b1,1'b0,1'b0,3'd0,8'h00},  // R5
    {1'b0,1'b1,1'b1,3'd7,8'h80},  // R2
    {1'b1,1'b1,1'b1,3'd7,8'h80}   // R7
  };

  function automatic string tag_of(input logic w, input logic v, input logic n);
    if (w && v && n) return "R7";
    if (v && !n)     return "R3";
    if (v)           return "R2";
    if (w)           return "R5";
    return "R9";
  endfunction

  function automatic logic [7:0] exp_mask(input logic [7:0] s);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j <= i; j++)
        if (s[j]) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [7:0] es);
    check(tag, {24'h0, rdata[7:0]}, {24'h0, es});
    check("R4", {24'h0, blk_mask}, {24'h0, exp_mask(es)});
    check("R8", {8'h0, rdata[31:8]}, 32'h0);
  endtask

  task automatic drive(input logic w, input logic v, input logic n, input logic [2:0] p);
    wr_en = w; vec_rd = v; nest_en = n; vec_prio = p;
    @(negedge clk);
    wr_en = 1'b0; vec_rd = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] es;
    // R1: reset with strobes active
    vec_rd = 1'b1; nest_en = 1'b1; vec_prio = 3'd4;
    repeat (3) @(negedge clk);
    check_all("R1", 8'h00);
    vec_rd = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check_all("R1", 8'h00);

    for (int k = 0; k < NV; k++) begin
      drive(VT[k][13], VT[k][12], VT[k][11], VT[k][10:8]);
      check_all(tag_of(VT[k][13], VT[k][12], VT[k][11]), VT[k][7:0]);
    end

    // R5: fill every level, then unwind one per write from bit 0 upward
    for (int p = 0; p < 8; p++) drive(1'b0, 1'b1, 1'b1, 3'(p));
    check_all("R2", 8'hFF);
    es = 8'hFF;
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 1'b0, 1'b0, 3'd0);
      es = es << 1;
      check_all("R5", es);
    end
    drive(1'b1, 1'b0, 1'b0, 3'd0);
    check_all("R6", 8'h00);

    // R7: entering a more urgent level than the one being retired
    drive(1'b0, 1'b1, 1'b1, 3'd6);
    drive(1'b1, 1'b1, 1'b1, 3'd0);
    check_all("R7", 8'h01);

    // R9: idle cycles hold both outputs
    repeat (3) @(negedge clk);
    check_all("R9", 8'h01);

    // R1: reset from a busy state wins over a same-cycle strobe
    drive(1'b0, 1'b1, 1'b1, 3'd7);
    check_all("R2", 8'h81);
    rst = 1'b1; vec_rd = 1'b1; nest_en = 1'b1; vec_prio = 3'd2;
    @(negedge clk);
    rst = 1'b0; vec_rd = 1'b0;
    check_all("R1", 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule